// File: doc/BRIEF.md
# Two-Level Carry Lookahead Adder

A purely combinational 16-bit adder that adds two operands and a carry-in and returns a 16-bit sum and a carry-out. The operand width is divided into four 4-bit groups. Each group forms a bit generate term (`a AND b`) and a bit propagate term (`a OR b`, inclusive OR). From these it builds its internal carries as fully expanded sums of products. Each group also produces a group generate and a group propagate.

A second-level lookahead unit takes the four group generate/propagate pairs and the carry-in. It forms the carries into bits 4, 8 and 12 and the final carry-out directly, so no carry ripples from one group to the next. Each sum bit is formed as `a XOR b XOR carry`. It is never taken from the OR-based propagate term.

The overall generate and propagate of the 16-bit block are brought out so that several blocks can feed a further lookahead level.

Top module: `cla_adder16`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + c_i` for every input combination.
- R2: `c_o` equals bit 16 of `a_i + b_i + c_i`.
- R3: `grp_g_o` is 1 exactly when `a_i + b_i` (carry-in ignored) is 2^16 or more.
- R4: `grp_p_o` is 1 exactly when every bit position has `a_i` or `b_i` set, and `c_o` always equals `grp_g_o OR (grp_p_o AND c_i)`.
- R5: A carry formed below a group boundary reaches the bits above it. With `a_i = 2^(4k) - 1`, `b_i = 1` and `c_i = 0`, the sum is exactly `2^(4k)` for k = 1, 2, 3, and 0x0FFF + 1 gives 0x1000.
- R6: A bit with both operands set counts as both generating and propagating. For example, 0xFFFF + 0xFFFF + 1 gives sum 0xFFFF with `c_o`, `grp_g_o` and `grp_p_o` all 1, and 0x8000 + 0x8000 gives `grp_g_o` = 1 with `grp_p_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| c_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| c_o | output | 1 | Carry out of bit 15 |
| grp_g_o | output | 1 | Block generate, for a higher lookahead level |
| grp_p_o | output | 1 | Block propagate (AND of all bit ORs) |

## Verification
A bit position can generate a carry and propagate an incoming carry at the same moment. The same holds for a whole group: its generate and propagate can both be 1 while the carry-in is also 1. The bench provokes this with operands that share set bits (0xFFFF + 0xFFFF + 1, 0xFFFF + 0x0001, and random vectors, which overlap often). It judges the outcome on three things: the sum and carry-out against `a + b + c` computed in the bench, the generate and propagate flags against their arithmetic definitions, and the identity `c_o = G | (P & c_i)`.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int MAX_W = 32;

  // Expanded sum-of-products carry into position k from gen/prop below it.
  function automatic logic sop_carry(input logic [MAX_W-1:0] gen,
                                     input logic [MAX_W-1:0] prop,
                                     input logic cin, input int k);
    logic acc, prod;
    acc = 1'b0;
    for (int j = 0; j < k; j++) begin
      prod = gen[j];
      for (int m = j + 1; m < k; m++) prod = prod & prop[m];
      acc = acc | prod;
    end
    prod = cin;
    for (int m = 0; m < k; m++) prod = prod & prop[m];
    return acc | prod;
  endfunction
endpackage

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int N = 4
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  input  logic         cin_i,
  output logic [N:1]   carry_o,
  output logic         grp_g_o,
  output logic         grp_p_o
);
  import cla_pkg::*;

  logic [MAX_W-1:0] gen_w, prop_w;
  assign gen_w  = MAX_W'(gen_i);
  assign prop_w = MAX_W'(prop_i);

  always_comb begin
    for (int k = 1; k <= N; k++) carry_o[k] = sop_carry(gen_w, prop_w, cin_i, k);
    grp_g_o = sop_carry(gen_w, prop_w, 1'b0, N);
    grp_p_o = &prop_i;
  end

  always_comb begin
    // R4
    top_carry_chk: assert (carry_o[N] == (grp_g_o | (grp_p_o & cin_i)))
      else $error("top_carry_chk");
    for (int k = 1; k <= N; k++) begin
      // R6
      gen_forces_chk: assert (!gen_i[k-1] || carry_o[k])
        else $error("gen_forces_chk");
    end
  end
endmodule

// File: rtl/cla_group.sv
module cla_group #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         grp_g_o,
  output logic         grp_p_o
);
  logic [W-1:0] bit_g, bit_p;
  logic [W:1]   carry;
  logic [W-1:0] c_in_bit;

  assign bit_g = a_i & b_i;
  assign bit_p = a_i | b_i;

  cla_lookahead #(.N(W)) u_bit_la (
    .gen_i   (bit_g),
    .prop_i  (bit_p),
    .cin_i   (cin_i),
    .carry_o (carry),
    .grp_g_o (grp_g_o),
    .grp_p_o (grp_p_o)
  );

  assign c_in_bit = {carry[W-1:1], cin_i};
  // sum uses XOR, never the OR-based propagate
  assign sum_o = a_i ^ b_i ^ c_in_bit;

  always_comb begin
    // R1
    grp_sum_chk: assert ({carry[W], sum_o} == ({1'b0, a_i} + {1'b0, b_i} + (W+1)'(cin_i)))
      else $error("grp_sum_chk");
  end
endmodule

// File: rtl/cla_adder16.sv
module cla_adder16 #(
  parameter int GROUP_W  = 4,
  parameter int N_GROUPS = 4
) (
  input  logic [GROUP_W*N_GROUPS-1:0] a_i,
  input  logic [GROUP_W*N_GROUPS-1:0] b_i,
  input  logic                        c_i,
  output logic [GROUP_W*N_GROUPS-1:0] sum_o,
  output logic                        c_o,
  output logic                        grp_g_o,
  output logic                        grp_p_o
);
  localparam int WIDTH = GROUP_W * N_GROUPS;

  logic [N_GROUPS-1:0] g_grp, p_grp, cin_grp;
  logic [N_GROUPS:1]   c_grp;

  assign cin_grp = {c_grp[N_GROUPS-1:1], c_i};

  for (genvar k = 0; k < N_GROUPS; k++) begin : g_grp_inst
    cla_group #(.W(GROUP_W)) u_grp (
      .a_i     (a_i[k*GROUP_W +: GROUP_W]),
      .b_i     (b_i[k*GROUP_W +: GROUP_W]),
      .cin_i   (cin_grp[k]),
      .sum_o   (sum_o[k*GROUP_W +: GROUP_W]),
      .grp_g_o (g_grp[k]),
      .grp_p_o (p_grp[k])
    );
  end

  cla_lookahead #(.N(N_GROUPS)) u_grp_la (
    .gen_i   (g_grp),
    .prop_i  (p_grp),
    .cin_i   (c_i),
    .carry_o (c_grp),
    .grp_g_o (grp_g_o),
    .grp_p_o (grp_p_o)
  );

  assign c_o = c_grp[N_GROUPS];

  logic [WIDTH:0] ref_full, ref_nocin;
  assign ref_full  = {1'b0, a_i} + {1'b0, b_i} + (WIDTH+1)'(c_i);
  assign ref_nocin = {1'b0, a_i} + {1'b0, b_i};

  always_comb begin
    // R2
    sum_carry_chk: assert ({c_o, sum_o} == ref_full) else $error("sum_carry_chk");
    // R3
    blk_gen_chk: assert (grp_g_o == ref_nocin[WIDTH]) else $error("blk_gen_chk");
    // R4
    blk_prop_chk: assert (grp_p_o == &(a_i | b_i)) else $error("blk_prop_chk");
  end

  for (genvar k = 1; k < N_GROUPS; k++) begin : g_bound_chk
    localparam logic [WIDTH-1:0] MASK = WIDTH'((WIDTH+1)'(1) << (k*GROUP_W)) - WIDTH'(1);
    logic [WIDTH:0] low_sum;
    assign low_sum = {1'b0, a_i & MASK} + {1'b0, b_i & MASK} + (WIDTH+1)'(c_i);
    always_comb begin
      // R5
      boundary_chk: assert (cin_grp[k] == low_sum[k*GROUP_W]) else $error("boundary_chk");
    end
  end
endmodule

// File: tb/cla_adder16_bench.sv
module cla_adder16_bench;
  localparam int W = 16;
  localparam int NV = 10;

  // {a, b, cin, sum, cout, g, p}
  localparam logic [W-1:0] TA [NV] = '{16'h0000, 16'hFFFF, 16'hFFFF, 16'hAAAA, 16'hAAAA,
                                       16'hFFFF, 16'h000F, 16'h0FFF, 16'h8000, 16'h1234};
  localparam logic [W-1:0] TB [NV] = '{16'h0000, 16'h0001, 16'h0000, 16'h5555, 16'h5555,
                                       16'hFFFF, 16'h0001, 16'h0001, 16'h8000, 16'h4321};
  localparam logic         TC [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam logic [W-1:0] TS [NV] = '{16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 16'h0000,
                                       16'hFFFF, 16'h0010, 16'h1000, 16'h0000, 16'h5556};
  localparam logic         TO [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam logic         TG [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam logic         TP [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0] a, b, s;
  logic cin, co, gg, gp;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  cla_adder16 u_cla_adder16 (
    .a_i(a), .b_i(b), .c_i(cin),
    .sum_o(s), .c_o(co), .grp_g_o(gg), .grp_p_o(gp)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    @(posedge clk);
    a = x; b = y; cin = c;
    @(negedge clk);
  endtask

  task automatic check_ref;
    logic [W:0] full, noc;
    full = {1'b0, a} + {1'b0, b} + (W+1)'(cin);
    noc  = {1'b0, a} + {1'b0, b};
    check("R1 sum", 32'(s), 32'(full[W-1:0]));
    check("R2 cout", 32'(co), 32'(full[W]));
    check("R3 gen", 32'(gg), 32'(noc[W]));
    check("R4 prop", 32'(gp), 32'(&(a | b)));
    check("R4 cout identity", 32'(co), 32'(gg | (gp & cin)));
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: zero inputs give zero outputs (R1, R2)
    check("R1 reset sum", 32'(s), 32'h0);
    check("R2 reset cout", 32'(co), 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(TA[i], TB[i], TC[i]);
      check("R1 table sum", 32'(s), 32'(TS[i]));
      check("R2 table cout", 32'(co), 32'(TO[i]));
      check("R3 table gen", 32'(gg), 32'(TG[i]));
      check("R4 table prop", 32'(gp), 32'(TP[i]));
    end

    // R5: carry crossing each group boundary
    for (int k = 1; k < 4; k++) begin
      apply(W'((32'd1 << (4*k)) - 1), 16'h0001, 1'b0);
      check("R5 boundary", 32'(s), 32'd1 << (4*k));
      check("R5 no cout", 32'(co), 32'h0);
    end
    apply(16'hFFFF, 16'h0000, 1'b1);
    check("R5 full ripple sum", 32'(s), 32'h0);
    check("R5 full ripple cout", 32'(co), 32'h1);

    // R6: generate and propagate together
    apply(16'hFFFF, 16'hFFFF, 1'b1);
    check("R6 both sum", 32'(s), 32'hFFFF);
    check("R6 both g", 32'(gg), 32'h1);
    check("R6 both p", 32'(gp), 32'h1);
    apply(16'h8000, 16'h8000, 1'b1);
    check("R6 msb g", 32'(gg), 32'h1);
    check("R6 msb p", 32'(gp), 32'h0);
    check("R6 msb sum", 32'(s), 32'h0001);

    for (int i = 0; i < 400; i++) begin
      apply(W'($urandom), W'($urandom), 1'($urandom));
      check_ref();
    end
    finish_run();
  end
endmodule